// File: doc/BRIEF.md
# Multiphase Switching Clock Generator with Sync Detection

This block produces the switching clocks for a pair of step-down regulators that run half a period apart. It also drives a clock output that keeps further controllers in step. A single synchronisation pin picks the operating mode. Held low, the clock output copies the first regulator's clock. Held high, the clock output runs at twice the switching rate with a quarter-period lag, which suits four-phase systems. Toggled by an outside oscillator, the regulators divide that clock by two and the clock output follows the first regulator.

All timing comes from a fast reference clock. A slot counter cuts each internal switching period into four equal slots, so edges are available at 0, 90, 180 and 270 degrees. The sync pin is sampled as a digital signal. Its transitions are counted over a window of internal periods to decide whether an outside clock is present. Every mode change waits for a point where no output pulse is cut short: internal modes take over at slot boundaries, and the external clock takes over on one of its own rising edges.

Top module: `msync_phase_gen`

## Requirements
- R1: From the second clock edge after reset release onward, `phase_a_o` and `phase_b_o` are always at opposite levels.
- R2: With `sync_in` held low, `clk_out_o` equals `phase_a_o` in every cycle.
- R3: With `sync_in` held high, `clk_out_o` is high for SLOT_CYC cycles in every 2*SLOT_CYC cycles. Each of its rising edges falls in slot 1 or slot 3, so the first one comes SLOT_CYC cycles after each rise of `phase_a_o`.
- R4: In the internal modes, `phase_a_o` has a period of 4*SLOT_CYC cycles and is high for slots 0 and 1, which is 2*SLOT_CYC cycles.
- R5: In external mode, `phase_a_o` toggles on every rising edge of `sync_in`, so its period is twice the sync period. The output change appears SYNC_STAGES+1 clock edges after the sync edge is applied.
- R6: In external mode, `clk_out_o` equals `phase_a_o` in every cycle.
- R7: A detection window is WIN_PERIODS internal periods long. At the end of each window, two or more sync transitions inside it select external mode. Fewer transitions select the static mode named by the current level, so a single level change leads to a static mode.
- R8: No mode change produces a runt. Provided each sync half-period is at least SLOT_CYC cycles, every output level lasts at least SLOT_CYC cycles. Internal modes take over at slot starts. Entry to external mode holds the present output levels until a sync rising edge.
- R9: While `rst_n` is low, all three outputs are low and the mode is static-low.
- R10: If `sync_in` stops toggling during external mode, the block returns to the internal timebase in the static mode given by the held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Mode-select pin: static level or outside clock |
| phase_a_o | output | 1 | Switching clock of the first regulator |
| phase_b_o | output | 1 | Switching clock of the second regulator, 180 degrees offset |
| clk_out_o | output | 1 | Clock output for slave controllers |

## Verification
The bench builds the block with SLOT_CYC=4, WIN_PERIODS=4 and SYNC_STAGES=2. This gives a 16-cycle internal period and a 64-cycle detection window, so every mode and both directions of fallback fit into about two thousand cycles. An outside clock with a 20-cycle period gives a 40-cycle switching period and keeps each sync half-period above one slot, which is the condition for checking runt-free switching. With two synchroniser stages, the exact three-edge lag from a sync edge to the divided output can be checked.

// File: rtl/msync_pkg.sv
package msync_pkg;

    typedef enum logic [1:0] {
        SRC_TIED_LO = 2'd0,
        SRC_TIED_HI = 2'd1,
        SRC_EXT     = 2'd2,
        SRC_PARK    = 2'd3
    } src_mode_e;

    typedef struct packed {
        logic a;
        logic b;
        logic ck;
    } phase_out_t;

endpackage

// File: rtl/msync_input.sv
module msync_input #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic toggle_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], pin_i};
        st_d.prev = st_q.pipe[STAGES-1];
        level_o   = st_q.pipe[STAGES-1];
        toggle_o  = st_q.pipe[STAGES-1] ^ st_q.prev;
        rise_o    = st_q.pipe[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/msync_timebase.sv
module msync_timebase #(
    parameter int SLOT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] slot_o,
    output logic       slot_start_o,
    output logic       period_end_o
);

    localparam int CNT_W              = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(SLOT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       slot;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CMAX) begin
            st_d.cnt  = '0;
            st_d.slot = st_q.slot + 2'd1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        slot_o       = st_q.slot;
        slot_start_o = (st_q.cnt == '0);
        period_end_o = (st_q.cnt == CMAX) && (st_q.slot == 2'd3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a slot only moves on after its last count, and only by one
    assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot != $past(st_q.slot)) |-> ($past(st_q.cnt) == CMAX));
    assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot != $past(st_q.slot)) |-> (st_q.slot == $past(st_q.slot) + 2'd1));

endmodule

// File: rtl/msync_detect.sv
module msync_detect
    import msync_pkg::*;
#(
    parameter int WIN_PERIODS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    input  logic      toggle_i,
    input  logic      period_end_i,
    output src_mode_e pend_o
);

    localparam int WIN_W              = (WIN_PERIODS > 1) ? $clog2(WIN_PERIODS) : 1;
    localparam logic [WIN_W-1:0] WMAX = WIN_W'(WIN_PERIODS - 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [1:0]       tog;
        src_mode_e        pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (toggle_i && st_q.tog != 2'd2) st_d.tog = st_q.tog + 2'd1;
        if (period_end_i) begin
            if (st_q.win == WMAX) begin
                st_d.win = '0;
                if (st_d.tog == 2'd2)  st_d.pend = SRC_EXT;
                else if (level_i)      st_d.pend = SRC_TIED_HI;
                else                   st_d.pend = SRC_TIED_LO;
                st_d.tog = 2'd0;
            end else begin
                st_d.win = st_q.win + 1'b1;
            end
        end
        pend_o = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pend <= SRC_TIED_LO;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the pending decision moves only at the end of a window
    assert_pend_at_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend != $past(st_q.pend)) |-> $past(period_end_i));
    assert_pend_never_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend != SRC_PARK);

endmodule

// File: rtl/msync_phase_gen.sv
module msync_phase_gen
    import msync_pkg::*;
#(
    parameter int SLOT_CYC    = 8,
    parameter int WIN_PERIODS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic phase_a_o,
    output logic phase_b_o,
    output logic clk_out_o
);

    localparam int CNT_W                  = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(SLOT_CYC - 1);

    logic       sync_level, sync_toggle, sync_rise;
    logic [1:0] slot;
    logic       slot_start, period_end;
    src_mode_e  pend;

    msync_input #(.STAGES(SYNC_STAGES)) u_input (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (sync_in),
        .level_o  (sync_level),
        .toggle_o (sync_toggle),
        .rise_o   (sync_rise)
    );

    msync_timebase #(.SLOT_CYC(SLOT_CYC)) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_o       (slot),
        .slot_start_o (slot_start),
        .period_end_o (period_end)
    );

    msync_detect #(.WIN_PERIODS(WIN_PERIODS)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_i      (sync_level),
        .toggle_i     (sync_toggle),
        .period_end_i (period_end),
        .pend_o       (pend)
    );

    typedef struct packed {
        src_mode_e        mode;
        logic             ext_ph;
        logic [CNT_W-1:0] hold;
        phase_out_t       out;
        logic             started;
    } st_t;

    st_t  st_d, st_q;
    logic hold_ok;

    always_comb begin
        st_d         = st_q;
        st_d.started = 1'b1;
        st_d.ext_ph  = st_q.ext_ph ^ sync_rise;
        hold_ok      = (st_q.hold == HOLD_MAX);

        case (st_q.mode)
            SRC_EXT: begin
                if (pend != SRC_EXT && hold_ok && slot_start) st_d.mode = pend;
            end
            SRC_PARK: begin
                if (pend == SRC_EXT) begin
                    if (sync_rise) st_d.mode = SRC_EXT;
                end else if (hold_ok && slot_start) begin
                    st_d.mode = pend;
                end
            end
            default: begin
                if (pend != st_q.mode && hold_ok && slot_start)
                    st_d.mode = (pend == SRC_EXT) ? SRC_PARK : pend;
            end
        endcase

        case (st_d.mode)
            SRC_EXT: begin
                st_d.out.a  = st_d.ext_ph;
                st_d.out.b  = ~st_d.ext_ph;
                st_d.out.ck = st_d.ext_ph;
            end
            SRC_PARK: st_d.out = st_q.out;
            SRC_TIED_HI: begin
                st_d.out.a  = ~slot[1];
                st_d.out.b  = slot[1];
                st_d.out.ck = slot[0];
            end
            default: begin
                st_d.out.a  = ~slot[1];
                st_d.out.b  = slot[1];
                st_d.out.ck = ~slot[1];
            end
        endcase

        if (st_d.out != st_q.out) st_d.hold = '0;
        else if (!hold_ok)        st_d.hold = st_q.hold + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= SRC_TIED_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_a_o = st_q.out.a;
    assign phase_b_o = st_q.out.b;
    assign clk_out_o = st_q.out.ck;

    assert_anti_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started |-> (phase_a_o ^ phase_b_o));
    assert_lo_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && st_q.mode == SRC_TIED_LO) |-> (clk_out_o == phase_a_o));
    assert_hi_quarter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SRC_TIED_HI && $past(st_q.mode) == SRC_TIED_HI && $rose(phase_a_o))
        |-> !clk_out_o);
    assert_ext_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SRC_EXT) |-> (clk_out_o == phase_a_o));
    // R8: parking freezes every output
    assert_park_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SRC_PARK && $past(st_q.mode) == SRC_PARK)
        |-> ($stable(phase_a_o) && $stable(clk_out_o)));

endmodule

// File: tb/sim_msync_phase_gen.sv
`timescale 1ns/1ps
module sim_msync_phase_gen;

    localparam int SLOT      = 4;
    localparam int WIN       = 4;
    localparam int STG       = 2;
    localparam int SYNC_HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic pa, pb, ck;

    always #2.5 clk = ~clk;

    msync_phase_gen #(.SLOT_CYC(SLOT), .WIN_PERIODS(WIN), .SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .phase_a_o(pa), .phase_b_o(pb), .clk_out_o(ck)
    );

    int vectors = 0, fails = 0, cyc = 0;
    bit sync_run = 0;
    int sph = 0, sync_rise_cyc = 0;

    // outside clock on the sync pin
    always @(negedge clk) begin
        if (sync_run) begin
            if (sph == 0) begin
                sync_in       <= 1'b1;
                sync_rise_cyc <= cyc;
            end else if (sph == SYNC_HALF) begin
                sync_in <= 1'b0;
            end
            sph <= (sph == 2*SYNC_HALF-1) ? 0 : sph + 1;
        end
    end

    // pulse-width monitor for R8
    bit mon_en = 0;
    int pw_bad = 0, pw_edges = 0;
    int run_len [3];
    bit seen [3];
    logic [2:0] prev_v = '0;
    always @(negedge clk) begin
        if (mon_en) begin
            for (int j = 0; j < 3; j++) begin
                if ({ck, pb, pa}[j] != prev_v[j]) begin
                    if (seen[j]) begin
                        pw_edges++;
                        if (run_len[j] < SLOT) pw_bad++;
                    end
                    seen[j]    = 1'b1;
                    run_len[j] = 1;
                end else begin
                    run_len[j]++;
                end
            end
        end
        prev_v = {ck, pb, pa};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int compl_bad, ck_diff;
    int a_gap_min, a_gap_max, a_hi_min, a_hi_max;
    int ck_gap_min, ck_gap_max, ck_hi_min, ck_hi_max;
    int off_min, off_max, lag_min, lag_max;

    task automatic observe(input int n);
        logic lpa, lck;
        int la, lck_r, v;
        bit want_off;
        compl_bad = 0; ck_diff = 0;
        a_gap_min = 9999; a_gap_max = -1; a_hi_min = 9999; a_hi_max = -1;
        ck_gap_min = 9999; ck_gap_max = -1; ck_hi_min = 9999; ck_hi_max = -1;
        off_min = 9999; off_max = -1; lag_min = 9999; lag_max = -1;
        lpa = pa; lck = ck; la = -1; lck_r = -1; want_off = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pa == pb) compl_bad++;
            if (ck != pa) ck_diff++;
            if (pa && !lpa) begin
                if (la >= 0) begin
                    v = i - la;
                    a_gap_min = (v < a_gap_min) ? v : a_gap_min;
                    a_gap_max = (v > a_gap_max) ? v : a_gap_max;
                end
                la = i; want_off = 1;
                v = cyc - sync_rise_cyc;
                lag_min = (v < lag_min) ? v : lag_min;
                lag_max = (v > lag_max) ? v : lag_max;
            end
            if (!pa && lpa && la >= 0) begin
                v = i - la;
                a_hi_min = (v < a_hi_min) ? v : a_hi_min;
                a_hi_max = (v > a_hi_max) ? v : a_hi_max;
            end
            if (ck && !lck) begin
                if (lck_r >= 0) begin
                    v = i - lck_r;
                    ck_gap_min = (v < ck_gap_min) ? v : ck_gap_min;
                    ck_gap_max = (v > ck_gap_max) ? v : ck_gap_max;
                end
                if (want_off) begin
                    v = i - la;
                    off_min = (v < off_min) ? v : off_min;
                    off_max = (v > off_max) ? v : off_max;
                    want_off = 0;
                end
                lck_r = i;
            end
            if (!ck && lck && lck_r >= 0) begin
                v = i - lck_r;
                ck_hi_min = (v < ck_hi_min) ? v : ck_hi_min;
                ck_hi_max = (v > ck_hi_max) ? v : ck_hi_max;
            end
            lpa = pa; lck = ck;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sync_in = 1'b0;
        wait_cyc(6);
        check(pa == 0 && pb == 0 && ck == 0, "R9", "outputs in reset",
              int'({pa, pb, ck}), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        mon_en = 1;
    endtask

    task automatic t_tied_low();
        wait_cyc(100);
        observe(80);
        check(compl_bad == 0, "R1", "low mode equal-level cycles", compl_bad, 0);
        check(ck_diff == 0, "R2", "clk_out differs from phase_a", ck_diff, 0);
        check(a_gap_min == 4*SLOT && a_gap_max == 4*SLOT, "R4", "low mode period",
              a_gap_max, 4*SLOT);
        check(a_hi_min == 2*SLOT && a_hi_max == 2*SLOT, "R4", "low mode high time",
              a_hi_max, 2*SLOT);
    endtask

    task automatic t_tied_high();
        sync_in = 1'b1;   // single level change: static-high expected (R7)
        wait_cyc(200);
        observe(80);
        check(compl_bad == 0, "R1", "high mode equal-level cycles", compl_bad, 0);
        check(ck_gap_min == 2*SLOT && ck_gap_max == 2*SLOT, "R3", "clk_out period",
              ck_gap_max, 2*SLOT);
        check(ck_hi_min == SLOT && ck_hi_max == SLOT, "R3", "clk_out high time",
              ck_hi_max, SLOT);
        check(off_min == SLOT && off_max == SLOT, "R3", "quarter-period lag",
              off_max, SLOT);
        check(a_gap_min == 4*SLOT && a_gap_max == 4*SLOT, "R7", "single toggle gives static mode",
              a_gap_max, 4*SLOT);
    endtask

    task automatic t_external();
        sph = 0;
        sync_run = 1;
        wait_cyc(300);
        observe(160);
        check(compl_bad == 0, "R1", "external equal-level cycles", compl_bad, 0);
        check(a_gap_min == 4*SYNC_HALF && a_gap_max == 4*SYNC_HALF, "R5", "divided period",
              a_gap_max, 4*SYNC_HALF);
        check(lag_min == STG+1 && lag_max == STG+1, "R5", "sync edge to phase_a lag",
              lag_max, STG+1);
        check(ck_diff == 0, "R6", "clk_out differs from phase_a", ck_diff, 0);
        check(a_hi_max == 2*SYNC_HALF, "R7", "external mode detected", a_hi_max, 2*SYNC_HALF);
    endtask

    task automatic t_fallback();
        sync_run = 0;
        @(negedge clk);
        sync_in = 1'b1;
        wait_cyc(300);
        observe(80);
        check(compl_bad == 0, "R10", "fallback equal-level cycles", compl_bad, 0);
        check(a_gap_min == 4*SLOT && a_gap_max == 4*SLOT, "R10", "fallback period",
              a_gap_max, 4*SLOT);
        check(off_min == SLOT && off_max == SLOT, "R10", "fallback to high-level mode",
              off_max, SLOT);
        sync_in = 1'b0;
        wait_cyc(200);
        observe(80);
        check(ck_diff == 0, "R7", "static low after high", ck_diff, 0);
        check(pw_bad == 0, "R8", "runt pulses", pw_bad, 0);
        check(pw_edges > 50, "R8", "edges watched", pw_edges, 51);
    endtask

    bit done = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000 && !done) begin
            fails++; vectors++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tied_low();
        t_tied_high();
        t_external();
        t_fallback();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule